// File: doc/BRIEF.md
# Broadcast Storm Limiter

This block caps the broadcast traffic accepted on one ingress port. It charges each broadcast frame in whole 64-byte blocks and keeps a running total for the current measurement window. When a frame's charge would push the total past the programmed quota, the frame is marked for drop and the total is left as it was. Frames that are not broadcast always pass and cost nothing.

The window is built from a 1 µs tick strobe. Its length depends on link speed: 67,000 ticks at 100 Mb/s and 500,000 ticks at 10 Mb/s. Both lengths are parameters. At every window edge the block total returns to zero. The quota and the speed select are sampled only at a window edge. The quota is 11 bits wide and is supplied as a 3-bit high part and an 8-bit low part.

A frame is observed as a start strobe, which carries the broadcast flag, followed by an end strobe, which carries the frame's total byte count. The forward or drop verdict appears one cycle after the end strobe.

Top module: `bcast_storm_limiter`

## Requirements
- R1: After reset `verdictValid` and `verdictDrop` are low, the active quota is 99 (0x063) and the active window is the 100 Mb/s length, whatever the configuration inputs hold.
- R2: A broadcast frame of N bytes costs ceil(N/64) blocks, so 1 to 64 bytes cost 1 block and 65 bytes cost 2 blocks.
- R3: A broadcast frame passes when the block total plus its cost is no greater than the active quota, and the total then grows by that cost. Otherwise the frame is dropped and the total does not change.
- R4: A frame whose broadcast flag is low always gets a forward verdict and leaves the block total unchanged.
- R5: `verdictValid` is high for exactly the one cycle after the cycle in which `frmEnd` is high. `verdictDrop` is valid in that cycle, with 1 meaning drop.
- R6: A window edge occurs on the TICKS_FAST-th tick of the window when the active speed is fast (`speedSlow`=0), or on the TICKS_SLOW-th tick when it is slow (`speedSlow`=1). The block total clears to zero at that edge.
- R7: The active quota is {`quotaHi`,`quotaLo`}, with `quotaHi` as bits [10:8]. It is loaded only at a window edge, so a change in the middle of a window has no effect until the next edge.
- R8: The speed select is loaded only at a window edge. The window timer restarts from zero at every edge, and the next window has the newly loaded length.
- R9: With an active quota of zero, every broadcast frame of nonzero length is dropped.
- R10: A frame whose `frmEnd` falls in the cycle of a window edge is judged against the new window, that is against a total of zero and the newly loaded quota, and its cost is charged to the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-cycle strobe every microsecond |
| speedSlow | input | 1 | 1 selects the 10 Mb/s window, 0 the 100 Mb/s window |
| quotaHi | input | QUOTA_W-8 | Upper bits of the block quota |
| quotaLo | input | 8 | Lower 8 bits of the block quota |
| frmStart | input | 1 | Start-of-frame strobe |
| frmBcast | input | 1 | Broadcast flag, sampled with frmStart |
| frmBytes | input | LEN_W | Frame byte count, sampled with frmEnd |
| frmEnd | input | 1 | End-of-frame strobe |
| verdictValid | output | 1 | Verdict strobe |
| verdictDrop | output | 1 | 1 = drop, 0 = forward |

## Verification
The bench goes after the edges of the cost rounding: 64 versus 65 bytes, and a frame that fills the quota exactly followed by a 1-byte frame. A design that rounds down, or that compares with "less than", would pass or drop the wrong one of these. It changes the quota and the speed in the middle of a window and counts ticks to one short of the edge. A design that loads its configuration early, or that miscounts the window length, would forward frames it should drop. The bench also ends a frame in the same cycle as a window edge, where a design using the old total or the old quota would drop a frame that must pass. Finally it checks that a zero quota drops every broadcast frame while non-broadcast frames still pass.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  // strobes from control to the datapath, valid for a single cycle
  typedef struct packed {
    logic windowEdge;   // current window ends on this edge
    logic judge;        // a frame ends this cycle and needs a verdict
    logic isBcast;      // broadcast flag of the frame being judged
  } ctlStrobes_t;

endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
#(
  parameter int TICKS_FAST = 67000,
  parameter int TICKS_SLOW = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickUs,
  input  logic        speedSlow,
  input  logic        frmStart,
  input  logic        frmBcast,
  input  logic        frmEnd,
  output ctlStrobes_t strobes
);

  localparam int MAX_TICKS = (TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST;
  localparam int TW        = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

  logic [TW-1:0] timer;
  logic [TW-1:0] limit;
  logic          slowActive;
  logic          bcastLatched;
  logic          edgeNow;

  // last tick index of the running window
  always_comb begin
    limit = slowActive ? TW'(TICKS_SLOW - 1) : TW'(TICKS_FAST - 1);
  end

  assign edgeNow = tickUs && (timer == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer        <= '0;
      slowActive   <= 1'b0;
      bcastLatched <= 1'b0;
    end else begin
      if (edgeNow) begin
        timer      <= '0;
        slowActive <= speedSlow;
      end else if (tickUs) begin
        timer <= timer + 1'b1;
      end
      if (frmStart) bcastLatched <= frmBcast;
    end
  end

  always_comb begin
    strobes.windowEdge = edgeNow;
    strobes.judge      = frmEnd;
    strobes.isBcast    = frmStart ? frmBcast : bcastLatched;
  end

  // R6: the timer never runs past the last tick of the active window
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    timer <= limit);

  // R8: the timer restarts from zero after every window edge
  p_edge_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.windowEdge |=> (timer == '0));

  // R8: the active speed changes only at a window edge
  p_speed_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.windowEdge |=> $stable(slowActive));

endmodule

// File: rtl/bsl_datapath.sv
module bsl_datapath
  import bsl_pkg::*;
#(
  parameter int              QUOTA_W     = 11,
  parameter int              LEN_W       = 16,
  parameter int              BLK_LOG2    = 6,
  parameter logic [QUOTA_W-1:0] QUOTA_RESET = 11'h063
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [QUOTA_W-1:0] quotaCfg,
  input  logic [LEN_W-1:0]   frmBytes,
  output logic               verdictValid,
  output logic               verdictDrop
);

  localparam int COST_W = LEN_W - BLK_LOG2 + 1;
  localparam int SUM_W  = ((COST_W > QUOTA_W) ? COST_W : QUOTA_W) + 1;

  logic [QUOTA_W-1:0] blkCount;
  logic [QUOTA_W-1:0] activeQuota;
  logic [COST_W-1:0]  cost;
  logic [QUOTA_W-1:0] effCount;
  logic [QUOTA_W-1:0] effQuota;
  logic [SUM_W-1:0]   need;
  logic               fits;
  logic               charge;

  // whole blocks plus one for any partial block
  always_comb begin
    cost = COST_W'(frmBytes[LEN_W-1:BLK_LOG2]) + COST_W'(|frmBytes[BLK_LOG2-1:0]);
  end

  // a frame ending on a window edge belongs to the new window
  always_comb begin
    effCount = strobes.windowEdge ? '0 : blkCount;
    effQuota = strobes.windowEdge ? quotaCfg : activeQuota;
    need     = SUM_W'(effCount) + SUM_W'(cost);
    fits     = (need <= SUM_W'(effQuota));
    charge   = strobes.judge && strobes.isBcast && fits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkCount     <= '0;
      activeQuota  <= QUOTA_RESET;
      verdictValid <= 1'b0;
      verdictDrop  <= 1'b0;
    end else begin
      if (charge)                  blkCount <= need[QUOTA_W-1:0];
      else if (strobes.windowEdge) blkCount <= '0;
      if (strobes.windowEdge) activeQuota <= quotaCfg;
      verdictValid <= strobes.judge;
      verdictDrop  <= strobes.judge && strobes.isBcast && !fits;
    end
  end

  // R3: the block total never exceeds the active quota
  p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    blkCount <= activeQuota);

  // R3: a drop that is not on a window edge leaves the total untouched
  p_drop_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && verdictDrop && !$past(strobes.windowEdge))
      |-> (blkCount == $past(blkCount)));

  // R4: frames that are not broadcast are never dropped
  p_plain_passes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !$past(strobes.isBcast)) |-> !verdictDrop);

  // R5: a verdict follows every frame end, one cycle later
  p_verdict_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.judge |=> verdictValid);

  // R5: no verdict appears without a frame end
  p_verdict_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.judge |=> !verdictValid);

  // R7: the quota is loaded only at a window edge
  p_quota_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.windowEdge |=> $stable(activeQuota));

  // R6: an edge with no charge leaves a zero total
  p_edge_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.windowEdge && !charge) |=> (blkCount == '0));

endmodule

// File: rtl/bcast_storm_limiter.sv
module bcast_storm_limiter
  import bsl_pkg::*;
#(
  parameter int TICKS_FAST = 67000,
  parameter int TICKS_SLOW = 500000,
  parameter int QUOTA_W    = 11,
  parameter int LEN_W      = 16,
  parameter int BLK_LOG2   = 6,
  parameter logic [QUOTA_W-1:0] QUOTA_RESET = 11'h063
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickUs,
  input  logic               speedSlow,
  input  logic [QUOTA_W-9:0] quotaHi,
  input  logic [7:0]         quotaLo,
  input  logic               frmStart,
  input  logic               frmBcast,
  input  logic [LEN_W-1:0]   frmBytes,
  input  logic               frmEnd,
  output logic               verdictValid,
  output logic               verdictDrop
);

  ctlStrobes_t        strobes;
  logic [QUOTA_W-1:0] quotaCfg;

  assign quotaCfg = {quotaHi, quotaLo};

  bsl_ctrl #(
    .TICKS_FAST (TICKS_FAST),
    .TICKS_SLOW (TICKS_SLOW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickUs    (tickUs),
    .speedSlow (speedSlow),
    .frmStart  (frmStart),
    .frmBcast  (frmBcast),
    .frmEnd    (frmEnd),
    .strobes   (strobes)
  );

  bsl_datapath #(
    .QUOTA_W     (QUOTA_W),
    .LEN_W       (LEN_W),
    .BLK_LOG2    (BLK_LOG2),
    .QUOTA_RESET (QUOTA_RESET)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .quotaCfg     (quotaCfg),
    .frmBytes     (frmBytes),
    .verdictValid (verdictValid),
    .verdictDrop  (verdictDrop)
  );

endmodule

// File: tb/bcast_storm_limiter_bench.sv
module bcast_storm_limiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FAST = 10;
  localparam int SLOW = 25;
  localparam int NVEC = 10;

  // vector layout: {bcast, bytes[15:0], expectDrop}; active quota 99, total starts at 0
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 16'd64,   1'b0},   // R2: 1 block, total 1
    {1'b1, 16'd65,   1'b0},   // R2: 2 blocks, total 3
    {1'b0, 16'd6000, 1'b0},   // R4: plain, total stays 3
    {1'b1, 16'd1,    1'b0},   // R2: 1 block, total 4
    {1'b1, 16'd1518, 1'b0},   // R2: 24 blocks, total 28
    {1'b1, 16'd4096, 1'b0},   // R3: 64 blocks, total 92
    {1'b1, 16'd512,  1'b1},   // R3: 8 blocks would give 100 > 99
    {1'b1, 16'd448,  1'b0},   // R3: 7 blocks, total exactly 99
    {1'b1, 16'd1,    1'b1},   // R3: quota used up
    {1'b0, 16'd64,   1'b0}    // R4: plain still passes
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickUs;
  logic        speedSlow;
  logic [2:0]  quotaHi;
  logic [7:0]  quotaLo;
  logic        frmStart;
  logic        frmBcast;
  logic [15:0] frmBytes;
  logic        frmEnd;
  logic        verdictValid;
  logic        verdictDrop;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcast_storm_limiter #(
    .TICKS_FAST (FAST),
    .TICKS_SLOW (SLOW)
  ) u_bcast_storm_limiter (
    .clk          (clk),
    .rstN         (rstN),
    .tickUs       (tickUs),
    .speedSlow    (speedSlow),
    .quotaHi      (quotaHi),
    .quotaLo      (quotaLo),
    .frmStart     (frmStart),
    .frmBcast     (frmBcast),
    .frmBytes     (frmBytes),
    .frmEnd       (frmEnd),
    .verdictValid (verdictValid),
    .verdictDrop  (verdictDrop)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickUs = 1'b1;
    end
    @(negedge clk);
    tickUs = 1'b0;
  endtask

  task automatic sendFrame(input logic bc, input int bytes, input logic expDrop, input string tag);
    @(negedge clk);
    frmStart = 1'b1;
    frmBcast = bc;
    @(negedge clk);
    frmStart = 1'b0;
    frmEnd   = 1'b1;
    frmBytes = 16'(bytes);
    @(negedge clk);
    frmEnd = 1'b0;
    check(verdictValid == 1'b1, {tag, " R5 valid"}, int'(verdictValid), 1);
    check(verdictDrop == expDrop, {tag, " drop"}, int'(verdictDrop), int'(expDrop));
    @(negedge clk);
    check(verdictValid == 1'b0, {tag, " R5 one-cycle"}, int'(verdictValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickUs = 1'b0; speedSlow = 1'b0;
    quotaHi = 3'd0; quotaLo = 8'd3;
    frmStart = 1'b0; frmBcast = 1'b0; frmBytes = '0; frmEnd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(verdictValid == 1'b0, "R1 reset valid", int'(verdictValid), 0);
    check(verdictDrop == 1'b0, "R1 reset drop", int'(verdictDrop), 0);

    // R1/R7: inputs say 3, but the first window runs on the reset quota of 99
    for (int v = 0; v < NVEC; v++) begin
      sendFrame(VEC[v][17], int'(VEC[v][16:1]), VEC[v][0], $sformatf("R3 vec%0d", v));
    end

    // R7: the edge loads quota 3
    tickN(FAST);
    sendFrame(1'b1, 192, 1'b0, "R7 quota3 fill");
    sendFrame(1'b1, 1, 1'b1, "R3 quota3 full");

    // R6: one tick short of the edge nothing clears; the last tick clears
    tickN(FAST - 1);
    sendFrame(1'b1, 1, 1'b1, "R6 before edge");
    tickN(1);
    sendFrame(1'b1, 1, 1'b0, "R6 after edge");

    // R7: a mid-window change waits for the edge (total 1 of 3)
    quotaHi = 3'd1; quotaLo = 8'd0;
    sendFrame(1'b1, 64, 1'b0, "R7 old quota kept");
    sendFrame(1'b1, 64, 1'b0, "R7 old quota at limit");
    sendFrame(1'b1, 64, 1'b1, "R7 old quota exceeded");
    tickN(FAST);
    sendFrame(1'b1, 16384, 1'b0, "R7 quota 256 fill");
    sendFrame(1'b1, 1, 1'b1, "R7 quota 256 full");

    // R8: speed change waits for the edge, then the window is SLOW long
    speedSlow = 1'b1;
    tickN(FAST - 1);
    sendFrame(1'b1, 1, 1'b1, "R8 still full");
    tickN(1);
    sendFrame(1'b1, 1, 1'b0, "R8 fast edge kept");
    sendFrame(1'b1, 16320, 1'b0, "R8 refill");
    tickN(FAST);
    sendFrame(1'b1, 1, 1'b1, "R6 slow no edge yet");
    tickN(SLOW - FAST - 1);
    sendFrame(1'b1, 1, 1'b1, "R6 slow one short");
    tickN(1);
    sendFrame(1'b1, 1, 1'b0, "R6 slow edge");

    // R9: zero quota
    speedSlow = 1'b0; quotaHi = 3'd0; quotaLo = 8'd0;
    tickN(SLOW);
    sendFrame(1'b1, 1, 1'b1, "R9 zero quota 1B");
    sendFrame(1'b1, 64, 1'b1, "R9 zero quota 64B");
    sendFrame(1'b0, 1500, 1'b0, "R4 plain under zero quota");

    // R10: frame end on the same cycle as the edge, new quota 2
    quotaLo = 8'd2;
    tickN(FAST - 1);
    @(negedge clk);
    frmStart = 1'b1; frmBcast = 1'b1;
    @(negedge clk);
    frmStart = 1'b0; frmEnd = 1'b1; frmBytes = 16'd64; tickUs = 1'b1;
    @(negedge clk);
    frmEnd = 1'b0; tickUs = 1'b0;
    check(verdictValid == 1'b1, "R10 valid", int'(verdictValid), 1);
    check(verdictDrop == 1'b0, "R10 judged on new window", int'(verdictDrop), 0);
    sendFrame(1'b1, 128, 1'b1, "R10 cost charged to new window");
    sendFrame(1'b1, 64, 1'b0, "R10 exact fill");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule